// File: doc/BRIEF.md
# DDR2 Command Timing Guard

The guard sits beside a DDR2-style memory controller and watches every decoded command that leaves it, together with the bank address and the A10 bit. It keeps its own model of the device. This model records whether each of the four banks is idle or holds an open row. It also records any recovery time a bank still owes after a precharge, and whether the device is in self refresh. The guard also tracks the exit windows that follow self refresh and the short window in which a running burst must not be cut off.

For each command, the guard decides whether the command is legal at that moment. When a rule is broken, the guard raises a one-cycle violation flag on the following clock, together with a 3-bit code that names the rule. The command that broke the rule is treated as dropped and does not change the model. The guard also gives a ready output for each command class, so the controller can see before issuing whether a command would pass. Write recovery, precharge time and the self-refresh exit window are taken from configuration inputs. These are held constant while traffic runs.

Top module: `ddr2_cmd_guard`

## Requirements
- R1: After reset, the guard reports no violation (flag 0, code 0). All banks are idle and every ready output is 1.
- R2: Command codes on `cmd` are: 0 NOP, 1 deselect, 2 ACTIVATE, 3 READ, 4 WRITE, 5 PRECHARGE, 6 REFRESH, 7 self-refresh entry, 8 self-refresh exit, 9 burst stop. ACTIVATE opens bank `ba`. A READ or WRITE to an idle bank, or an ACTIVATE to an open bank, gives code 7. PRECHARGE closes bank `ba`, or all banks when `a10`=1.
- R3: A READ or WRITE with `a10`=1 closes its bank after the access. With `a10`=0 the row stays open.
- R4: A WRITE with `a10`=1 at cycle W blocks ACTIVATE to that bank until cycle W+`cfg_wr`+`cfg_trp`. An earlier ACTIVATE gives code 4. Other banks are not affected.
- R5: A PRECHARGE that closes an open bank, or a READ with `a10`=1, at cycle P blocks ACTIVATE to that bank until cycle P+`cfg_trp` (code 4).
- R6: Self-refresh entry is legal only when all banks are idle and none owes recovery. Otherwise it gives code 1. REFRESH under the same condition gives code 7.
- R7: While in self refresh, only NOP, deselect and self-refresh exit are legal, and anything else gives code 7. Self-refresh exit outside self refresh gives code 7.
- R8: After a legal exit at cycle S, any command other than NOP or deselect before cycle S+`cfg_txsnr` gives code 2.
- R9: After a legal exit at cycle S, a READ before cycle S+200 gives code 3.
- R10: A READ or WRITE in the cycle right after a legal READ or WRITE interrupts the burst and gives code 5. Two cycles later it is legal.
- R11: Burst stop gives code 6. Command codes 10 to 15 give code 7.
- R12: Each violation gives `viol`=1 with its code for exactly the clock after the command. A flagged command leaves the bank state and the self-refresh state unchanged.
- R13: When several rules apply, one code is chosen in this order: self-refresh state (7), exit window (2), burst stop (6), read window (3), burst interruption (5), recovery (4), self-refresh entry (1), other state errors (7).
- R14: `rdy_act[b]` is 1 when ACTIVATE to bank b would be legal. `rdy_rd` and `rdy_wr` show that the timing windows allow a column command. `rdy_sre` shows that self-refresh entry would be legal. `rdy_pre` shows that a precharge would be legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd | input | 4 | Decoded command code (R2) |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select |
| cfg_wr | input | 4 | Write recovery in clocks |
| cfg_trp | input | 4 | Precharge time in clocks |
| cfg_txsnr | input | 8 | Self-refresh exit window for non-read commands, in clocks |
| viol | output | 1 | One-cycle violation flag |
| viol_code | output | 3 | Code of the broken rule |
| rdy_act | output | 4 | Per-bank ACTIVATE ready |
| rdy_rd | output | 1 | READ timing ready |
| rdy_wr | output | 1 | WRITE timing ready |
| rdy_pre | output | 1 | PRECHARGE ready |
| rdy_sre | output | 1 | Self-refresh entry ready |

## Verification
The assertions assume that the configuration inputs stay stable while commands flow. They also assume that `cmd` carries one of the sixteen codes on every clock. Under these assumptions, a bank can never open while it still owes recovery, and self refresh can only hold with all banks idle.

The bench sets the configuration once before reset is released. It then drives one command per clock at the falling edge and parks NOP between scenarios, so these assumptions always hold. Every window is probed one cycle before and exactly at its edge.

// File: rtl/guard_pkg.sv
package guard_pkg;
   typedef enum logic [3:0] {
      CMD_NOP   = 4'd0,
      CMD_DESEL = 4'd1,
      CMD_ACT   = 4'd2,
      CMD_RD    = 4'd3,
      CMD_WR    = 4'd4,
      CMD_PRE   = 4'd5,
      CMD_REF   = 4'd6,
      CMD_SRE   = 4'd7,
      CMD_SRX   = 4'd8,
      CMD_BST   = 4'd9
   } cmd_e;

   typedef enum logic [2:0] {
      V_NONE     = 3'd0,
      V_SRE_BUSY = 3'd1,
      V_EXIT_WIN = 3'd2,
      V_READ_WIN = 3'd3,
      V_RECOVERY = 3'd4,
      V_BURST    = 3'd5,
      V_UNSUPP   = 3'd6,
      V_STATE    = 3'd7
   } viol_e;
endpackage

// File: rtl/guard_window.sv
// Loadable down-counter: busy while the count is non-zero.
module guard_window #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         busy
);
   generate
      if (W < 1) begin : g_bad_w
         $error("guard_window: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/guard_bank.sv
// One bank: open/idle flag plus recovery window.
module guard_bank #(
   parameter int REC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_i,
   input  logic             close_i,
   input  logic [REC_W-1:0] rec_val,
   output logic             active_o,
   output logic             rec_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        active_o <= 1'b0;
      else if (open_i)   active_o <= 1'b1;
      else if (close_i)  active_o <= 1'b0;
   end

   guard_window #(.W(REC_W)) u_rec (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (close_i),
      .load_val (rec_val),
      .busy     (rec_o)
   );

   // R4
   act_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_o) |-> !$past(rec_o));
endmodule

// File: rtl/guard_judge.sv
// Picks the single violation code for the command in this cycle.
module guard_judge
   import guard_pkg::*;
(
   input  logic [3:0] cmd,
   input  logic       tgt_active,
   input  logic       tgt_rec,
   input  logic       any_busy,
   input  logic       in_sr,
   input  logic       xs_busy,
   input  logic       rd_busy,
   input  logic       burst_busy,
   output logic [2:0] code
);
   viol_e v;
   logic  is_nop, is_col, known;

   always_comb begin
      is_nop = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
      is_col = (cmd == CMD_RD) || (cmd == CMD_WR);
      known  = (cmd <= CMD_BST);
      v      = V_NONE;
      if (is_nop)                                v = V_NONE;
      else if (in_sr)                            v = (cmd == CMD_SRX) ? V_NONE : V_STATE;
      else if (cmd == CMD_SRX)                   v = V_STATE;
      else if (xs_busy)                          v = V_EXIT_WIN;
      else if (cmd == CMD_BST)                   v = V_UNSUPP;
      else if (cmd == CMD_RD && rd_busy)         v = V_READ_WIN;
      else if (is_col && burst_busy)             v = V_BURST;
      else if (cmd == CMD_ACT && tgt_rec)        v = V_RECOVERY;
      else if (cmd == CMD_SRE && any_busy)       v = V_SRE_BUSY;
      else if (is_col && !tgt_active)            v = V_STATE;
      else if (cmd == CMD_ACT && tgt_active)     v = V_STATE;
      else if (cmd == CMD_REF && any_busy)       v = V_STATE;
      else if (!known)                           v = V_STATE;
      code = v;
   end
endmodule

// File: rtl/ddr2_cmd_guard.sv
module ddr2_cmd_guard
   import guard_pkg::*;
#(
   parameter int BANKS     = 4,
   parameter int CFG_W     = 4,
   parameter int CNT_W     = 8,
   parameter int RD_EXIT   = 200,
   parameter int BURST_GAP = 2,
   localparam int BA_W     = $clog2(BANKS),
   localparam int REC_W    = CFG_W + 1,
   localparam int BG_W     = (BURST_GAP > 1) ? $clog2(BURST_GAP) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       cmd,
   input  logic [BA_W-1:0]  ba,
   input  logic             a10,
   input  logic [CFG_W-1:0] cfg_wr,
   input  logic [CFG_W-1:0] cfg_trp,
   input  logic [CNT_W-1:0] cfg_txsnr,
   output logic             viol,
   output logic [2:0]       viol_code,
   output logic [BANKS-1:0] rdy_act,
   output logic             rdy_rd,
   output logic             rdy_wr,
   output logic             rdy_pre,
   output logic             rdy_sre
);
   generate
      if (BANKS < 2 || (1 << BA_W) != BANKS) begin : g_bad_banks
         $error("ddr2_cmd_guard: BANKS must be a power of two, at least 2");
      end
      if (RD_EXIT < 1 || RD_EXIT > (1 << CNT_W)) begin : g_bad_rdexit
         $error("ddr2_cmd_guard: RD_EXIT must fit the CNT_W counter");
      end
      if (BURST_GAP < 1) begin : g_bad_gap
         $error("ddr2_cmd_guard: BURST_GAP must be at least 1");
      end
   endgenerate

   logic [BANKS-1:0] active, rec;
   logic             in_sr, xs_busy, rd_busy, burst_busy;
   logic [2:0]       code;
   logic             is_nop, legal, any_busy;
   logic [REC_W-1:0] dal, dal_m1, trp_m1, close_val;
   logic [CNT_W-1:0] txsnr_m1;

   assign is_nop   = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
   assign legal    = !is_nop && (code == V_NONE);
   assign any_busy = (|active) || (|rec);

   // Recovery lengths, counted from the command cycle.
   assign dal       = REC_W'(cfg_wr) + REC_W'(cfg_trp);
   assign dal_m1    = (dal == '0) ? '0 : dal - 1'b1;
   assign trp_m1    = (cfg_trp == '0) ? '0 : REC_W'(cfg_trp) - 1'b1;
   assign close_val = (cmd == CMD_WR) ? dal_m1 : trp_m1;
   assign txsnr_m1  = (cfg_txsnr == '0) ? '0 : cfg_txsnr - 1'b1;

   guard_judge u_judge (
      .cmd        (cmd),
      .tgt_active (active[ba]),
      .tgt_rec    (rec[ba]),
      .any_busy   (any_busy),
      .in_sr      (in_sr),
      .xs_busy    (xs_busy),
      .rd_busy    (rd_busy),
      .burst_busy (burst_busy),
      .code       (code)
   );

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic hit, open_b, close_b;
      assign hit     = (ba == BA_W'(b));
      assign open_b  = legal && (cmd == CMD_ACT) && hit;
      assign close_b = legal && (
                          (((cmd == CMD_RD) || (cmd == CMD_WR)) && a10 && hit) ||
                          ((cmd == CMD_PRE) && (a10 || hit) && active[b]));
      guard_bank #(.REC_W(REC_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .open_i   (open_b),
         .close_i  (close_b),
         .rec_val  (close_val),
         .active_o (active[b]),
         .rec_o    (rec[b])
      );
      assign rdy_act[b] = !in_sr && !xs_busy && !active[b] && !rec[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          in_sr <= 1'b0;
      else if (legal && cmd == CMD_SRE)    in_sr <= 1'b1;
      else if (legal && cmd == CMD_SRX)    in_sr <= 1'b0;
   end

   guard_window #(.W(CNT_W)) u_xs (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (legal && cmd == CMD_SRX),
      .load_val (txsnr_m1),
      .busy     (xs_busy)
   );

   guard_window #(.W(CNT_W)) u_rdwin (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (legal && cmd == CMD_SRX),
      .load_val (CNT_W'(RD_EXIT - 1)),
      .busy     (rd_busy)
   );

   guard_window #(.W(BG_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (legal && (cmd == CMD_RD || cmd == CMD_WR)),
      .load_val (BG_W'(BURST_GAP - 1)),
      .busy     (burst_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol      <= 1'b0;
         viol_code <= 3'd0;
      end else begin
         viol      <= (code != V_NONE);
         viol_code <= code;
      end
   end

   assign rdy_pre = !in_sr && !xs_busy;
   assign rdy_rd  = !in_sr && !xs_busy && !rd_busy && !burst_busy;
   assign rdy_wr  = !in_sr && !xs_busy && !burst_busy;
   assign rdy_sre = !in_sr && !xs_busy && !any_busy;

   // R6
   sr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_sr |-> !any_busy);
   // R7
   sr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_sr) |-> ($past(cmd) == CMD_SRX));
   // R10
   burst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_busy) |-> ($past(cmd) == CMD_RD || $past(cmd) == CMD_WR));
   // R8
   exit_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xs_busy && !$past(xs_busy)) |-> ($past(cmd) == CMD_SRX));
endmodule

// File: tb/ddr2_cmd_guard_bench.sv
`timescale 1ns/1ps
module ddr2_cmd_guard_bench;
   localparam int NOP = 0, DES = 1, ACT = 2, RD = 3, WR = 4, PRE = 5,
                  REF = 6, SRE = 7, SRX = 8, BST = 9;
   localparam int TWR = 3, TRP = 2, TXS = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cmd = 4'd0;
   logic [1:0] ba = 2'd0;
   logic       a10 = 1'b0;
   logic       viol, rdy_rd, rdy_wr, rdy_pre, rdy_sre;
   logic [2:0] viol_code;
   logic [3:0] rdy_act;

   int cyc = 0, checks = 0, errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ddr2_cmd_guard u_ddr2_cmd_guard (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .a10(a10),
      .cfg_wr(4'(TWR)), .cfg_trp(4'(TRP)), .cfg_txsnr(8'(TXS)),
      .viol(viol), .viol_code(viol_code), .rdy_act(rdy_act),
      .rdy_rd(rdy_rd), .rdy_wr(rdy_wr), .rdy_pre(rdy_pre), .rdy_sre(rdy_sre));

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // Drives one command, returns its cycle, checks flag and code.
   task automatic issue(input int c, input int b, input bit a, input int exp_code,
                        input string req, output int t);
      t = cyc;
      cmd = 4'(c); ba = 2'(b); a10 = a;
      @(posedge clk); #1;
      cmd = 4'(NOP); a10 = 1'b0;
      chk({req, " flag"}, int'(viol), (exp_code != 0) ? 1 : 0);
      chk({req, " code"}, int'(viol_code), exp_code);
      @(negedge clk);
   endtask

   task automatic wait_to(input int target);
      while (cyc < target) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 viol", int'(viol), 0);
      chk("R1 code", int'(viol_code), 0);
      chk("R1 rdy_act", int'(rdy_act), 15);
      chk("R1 rdy_sre", int'(rdy_sre), 1);
      chk("R1 rdy_rd", int'(rdy_rd), 1);
      chk("R1 rdy_pre", int'(rdy_pre), 1);
   endtask

   task automatic t_bank_burst;
      int t, u;
      issue(ACT, 0, 0, 0, "R2 act b0", t);
      issue(RD, 1, 0, 7, "R2 read idle bank", t);
      issue(ACT, 0, 0, 7, "R2 act open bank", t);
      chk("R12 flagged act keeps state rdy_act0", int'(rdy_act[0]), 0);
      issue(RD, 0, 0, 0, "R3 read no ap keeps row", t);
      issue(RD, 0, 0, 5, "R10 interrupt", u);
      issue(NOP, 0, 0, 0, "R12 one-cycle pulse", u);
      issue(RD, 0, 0, 0, "R10 gap reached", u);
      chk("R3 row still open", int'(rdy_act[0]), 0);
      issue(BST, 0, 0, 6, "R11 burst stop", u);
      issue(4'd12, 0, 0, 7, "R11 undefined code", u);
   endtask

   task automatic t_write_ap;
      int w, t;
      issue(WR, 0, 1, 0, "R3 write ap", w);
      chk("R14 rdy_act0 recovering", int'(rdy_act[0]), 0);
      issue(ACT, 1, 0, 0, "R4 other bank unaffected", t);
      issue(ACT, 0, 0, 4, "R4 early act", t);
      wait_to(w + TWR + TRP - 1);
      issue(ACT, 0, 0, 4, "R4 act one cycle early", t);
      chk("R4 rdy_act0 at edge", int'(rdy_act[0]), 1);
      issue(ACT, 0, 0, 0, "R4 act at edge", t);
   endtask

   task automatic t_pre_sre;
      int r, p, t;
      issue(RD, 1, 1, 0, "R5 read ap", r);
      issue(ACT, 1, 0, 4, "R5 act within trp", t);
      issue(REF, 0, 0, 7, "R6 refresh with open bank", t);
      chk("R14 rdy_sre busy", int'(rdy_sre), 0);
      issue(SRE, 0, 0, 1, "R6 sre with open bank", t);
      issue(PRE, 2, 1, 0, "R2 precharge all", p);
      issue(SRE, 0, 0, 1, "R6 sre during trp", t);
      chk("R14 rdy_sre idle", int'(rdy_sre), 1);
      issue(SRE, 0, 0, 0, "R6 sre legal", t);
   endtask

   task automatic t_self_refresh;
      int s, t;
      issue(ACT, 0, 0, 7, "R7 act in self refresh", t);
      chk("R14 rdy_act in sr", int'(rdy_act), 0);
      issue(DES, 0, 0, 0, "R7 deselect in sr", t);
      issue(SRX, 0, 0, 0, "R7 exit", s);
      issue(ACT, 2, 0, 2, "R8 act in exit window", t);
      issue(BST, 0, 0, 2, "R13 exit window beats burst stop", t);
      wait_to(s + TXS - 1);
      issue(ACT, 2, 0, 2, "R8 last window cycle", t);
      issue(ACT, 1, 0, 0, "R8 act at window edge", t);
      chk("R14 rdy_rd in read window", int'(rdy_rd), 0);
      chk("R14 rdy_wr outside burst", int'(rdy_wr), 1);
      issue(RD, 1, 0, 3, "R9 early read", t);
      wait_to(s + 199);
      issue(RD, 1, 0, 3, "R9 read one cycle early", t);
      issue(RD, 1, 0, 0, "R9 read at 200", t);
      issue(RD, 3, 0, 5, "R13 burst beats idle-bank error", t);
      issue(SRX, 0, 0, 7, "R7 exit outside sr", t);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bank_burst();
      t_write_ap();
      t_pre_sre();
      t_self_refresh();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule